// File: doc/BRIEF.md
# Pipeline Stall Controller Without Forwarding

This block decides, every cycle, whether a five-stage in-order pipeline (fetch, decode, execute, memory, writeback) must stop parts of itself. The pipeline has no result bypass paths and no branch prediction, and it may share one memory between instruction fetch and data access. The controller looks at the decode, execute and memory stage registers and produces three control lines. The first freezes the program counter and the fetch/decode register. The second turns the instruction entering execute into a bubble. The third keeps fetch off the memory.

Three rules drive the outputs. A decode-stage instruction whose source register is still being produced in execute or memory waits in decode. A producer that has reached writeback no longer blocks, because the register file is written in the first half of the cycle and read in the second. A load or store in the memory stage takes the only memory port away from fetch, unless the block is built for separate instruction and data memories. While a branch sits in decode or execute, nothing new is fetched, because the next address is known only once execute is done.

The three control lines are combinational functions of the stage registers. Clock and reset serve the reset gating and the built-in checks.

Top module: `hazard_stall_ctrl`

## Requirements
- R1: A valid decode instruction with a source in use whose index equals the destination of a valid, register-writing instruction in execute raises `stall_fd` and `bubble_ex` in the same cycle.
- R2: The same match against a valid, register-writing instruction in the memory stage also raises `stall_fd` and `bubble_ex`.
- R3: Only the execute and memory stages are treated as producers. When neither holds a matching writer, `stall_fd` stays low, so a producer in writeback never delays its consumer.
- R4: Register index 0 never creates a dependency, even when a producer writes index 0.
- R5: A stage with its valid bit low or its register-write flag low is not a producer. A source whose use flag is low is not a consumer.
- R6: With the unified-memory build (`MEM_SPLIT` = 0), a valid memory-stage instruction that has its memory-access flag set raises `fetch_hold`.
- R7: With the split-memory build (`MEM_SPLIT` = 1), memory-stage accesses never raise `fetch_hold`.
- R8: A valid branch in decode or in execute raises `fetch_hold`. A branch flag on an invalid stage has no effect.
- R9: When a data dependency and a port conflict coincide, `stall_fd` and `fetch_hold` are both high. `stall_fd` stays high for as long as the dependency remains, even after the port conflict has gone.
- R10: An invalid decode slot never raises `stall_fd`.
- R11: While `rst_n` is low, all three outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the built-in checks |
| rst_n | input | 1 | Active-low reset; forces all outputs low |
| id_vld | input | 1 | Decode stage holds an instruction |
| id_br | input | 1 | Decode instruction is a branch |
| id_src_use | input | NUM_SRC | Per-source read flag, bit k for source k |
| id_src_idx | input | NUM_SRC*REG_AW | Source indices; source k at bits [k*REG_AW +: REG_AW] |
| ex_vld | input | 1 | Execute stage holds an instruction |
| ex_wen | input | 1 | Execute instruction writes a register |
| ex_br | input | 1 | Execute instruction is a branch |
| ex_rd | input | REG_AW | Execute destination index |
| mem_vld | input | 1 | Memory stage holds an instruction |
| mem_wen | input | 1 | Memory-stage instruction writes a register |
| mem_acc | input | 1 | Memory-stage instruction is a load or store |
| mem_rd | input | REG_AW | Memory-stage destination index |
| stall_fd | output | 1 | Hold PC and the fetch/decode register |
| bubble_ex | output | 1 | Load a bubble (valid low) into execute |
| fetch_hold | output | 1 | No fetch this cycle; PC holds, and decode gets a bubble unless `stall_fd` is high |

## Verification
The bench goes after a source that matches only through its second index, a producer writing register 0, and flags that are set on invalid stages. A comparator that ignored the index-0 rule or the valid bits would stall forever on harmless traffic. It drives a load with and without a register write into both a unified and a split build. A design with the port check wired the wrong way would either starve fetch with split memories or fetch into a busy port. It also steps a hazard through a port conflict until both clear, and confirms that the freeze tracks the dependency alone, which a controller that merged the two causes into one hold would get wrong.

// File: rtl/hz_pkg.sv
package hz_pkg;
   // memory organisation seen by the fetch stage
   typedef enum logic {
      MEM_UNIFIED = 1'b0,
      MEM_SPLIT   = 1'b1
   } mem_arch_e;

   // producer stages compared against decode sources
   localparam int unsigned PROD_STAGES = 2;
   localparam int unsigned PROD_EX     = 0;
   localparam int unsigned PROD_MEM    = 1;
endpackage

// File: rtl/hz_src_dep.sv
// Compares one decode source index against every in-flight producer.
module hz_src_dep #(
   parameter int unsigned AW    = 5,
   parameter int unsigned NPROD = 2
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                src_use,
   input  logic [AW-1:0]       src_idx,
   input  logic [NPROD-1:0]    prod_vld,
   input  logic [NPROD-1:0]    prod_wen,
   input  logic [NPROD*AW-1:0] prod_rd,
   output logic                hit
);
   logic [NPROD-1:0] per_prod;
   logic             src_live;

   assign src_live = src_use && (src_idx != '0);

   generate
      for (genvar p = 0; p < NPROD; p++) begin : g_prod
         assign per_prod[p] = src_live && prod_vld[p] && prod_wen[p]
                              && (prod_rd[p*AW +: AW] == src_idx);
      end
   endgenerate

   assign hit = |per_prod;

   AST_ZERO_NO_DEP: assert property (@(posedge clk) disable iff (!rst_n)
      (src_idx == '0) |-> !hit);                                   // R4
   AST_UNUSED_NO_DEP: assert property (@(posedge clk) disable iff (!rst_n)
      !src_use |-> !hit);                                          // R5
endmodule

// File: rtl/hz_data_unit.sv
// Read-after-write hold for the decode stage (no bypass network).
module hz_data_unit #(
   parameter int unsigned AW    = 5,
   parameter int unsigned NSRC  = 2,
   parameter int unsigned NPROD = 2
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                id_vld,
   input  logic [NSRC-1:0]     src_use,
   input  logic [NSRC*AW-1:0]  src_idx,
   input  logic [NPROD-1:0]    prod_vld,
   input  logic [NPROD-1:0]    prod_wen,
   input  logic [NPROD*AW-1:0] prod_rd,
   output logic                data_hold
);
   logic [NSRC-1:0] src_hit;

   generate
      for (genvar s = 0; s < NSRC; s++) begin : g_src
         hz_src_dep #(.AW(AW), .NPROD(NPROD)) u_dep (
            .clk      (clk),
            .rst_n    (rst_n),
            .src_use  (src_use[s]),
            .src_idx  (src_idx[s*AW +: AW]),
            .prod_vld (prod_vld),
            .prod_wen (prod_wen),
            .prod_rd  (prod_rd),
            .hit      (src_hit[s])
         );
      end
   endgenerate

   assign data_hold = id_vld && (|src_hit);

   AST_EMPTY_ID_NO_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !id_vld |-> !data_hold);                                     // R10
   AST_NO_WRITER_NO_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (prod_wen == '0) |-> !data_hold);                            // R5
endmodule

// File: rtl/hz_port_unit.sv
// Structural conflict between fetch and data access on a shared memory.
module hz_port_unit #(
   parameter hz_pkg::mem_arch_e MEM_ARCH = hz_pkg::MEM_UNIFIED
) (
   input  logic mem_vld,
   input  logic mem_acc,
   output logic port_hold
);
   generate
      if (MEM_ARCH == hz_pkg::MEM_UNIFIED) begin : g_shared
         assign port_hold = mem_vld && mem_acc;
      end else begin : g_split
         logic unused_in;
         assign unused_in = mem_vld ^ mem_acc;
         assign port_hold = 1'b0;
      end
   endgenerate
endmodule

// File: rtl/hz_branch_unit.sv
// Keeps fetch idle while an unresolved branch is in decode or execute.
module hz_branch_unit (
   input  logic clk,
   input  logic rst_n,
   input  logic id_vld,
   input  logic id_br,
   input  logic ex_vld,
   input  logic ex_br,
   output logic br_hold
);
   logic br_in_id;
   logic br_in_ex;

   assign br_in_id = id_vld && id_br;
   assign br_in_ex = ex_vld && ex_br;
   assign br_hold  = br_in_id || br_in_ex;

   AST_GHOST_BRANCH: assert property (@(posedge clk) disable iff (!rst_n)
      (!id_vld && !ex_vld) |-> !br_hold);                          // R8
endmodule

// File: rtl/hazard_stall_ctrl.sv
module hazard_stall_ctrl #(
   parameter int unsigned       REG_AW   = 5,
   parameter int unsigned       NUM_SRC  = 2,
   parameter hz_pkg::mem_arch_e MEM_ARCH = hz_pkg::MEM_UNIFIED
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      id_vld,
   input  logic                      id_br,
   input  logic [NUM_SRC-1:0]        id_src_use,
   input  logic [NUM_SRC*REG_AW-1:0] id_src_idx,
   input  logic                      ex_vld,
   input  logic                      ex_wen,
   input  logic                      ex_br,
   input  logic [REG_AW-1:0]         ex_rd,
   input  logic                      mem_vld,
   input  logic                      mem_wen,
   input  logic                      mem_acc,
   input  logic [REG_AW-1:0]         mem_rd,
   output logic                      stall_fd,
   output logic                      bubble_ex,
   output logic                      fetch_hold
);
   localparam int unsigned NPROD = hz_pkg::PROD_STAGES;

   generate
      if (REG_AW < 1 || REG_AW > 8) begin : g_bad_aw
         $error("hazard_stall_ctrl: REG_AW out of range");
      end
      if (NUM_SRC < 1 || NUM_SRC > 4) begin : g_bad_src
         $error("hazard_stall_ctrl: NUM_SRC out of range");
      end
   endgenerate

   logic [NPROD-1:0]        prod_vld;
   logic [NPROD-1:0]        prod_wen;
   logic [NPROD*REG_AW-1:0] prod_rd;
   logic                    data_hold;
   logic                    port_hold;
   logic                    br_hold;

   assign prod_vld[hz_pkg::PROD_EX]  = ex_vld;
   assign prod_vld[hz_pkg::PROD_MEM] = mem_vld;
   assign prod_wen[hz_pkg::PROD_EX]  = ex_wen;
   assign prod_wen[hz_pkg::PROD_MEM] = mem_wen;
   assign prod_rd[hz_pkg::PROD_EX*REG_AW  +: REG_AW] = ex_rd;
   assign prod_rd[hz_pkg::PROD_MEM*REG_AW +: REG_AW] = mem_rd;

   hz_data_unit #(.AW(REG_AW), .NSRC(NUM_SRC), .NPROD(NPROD)) u_data (
      .clk       (clk),
      .rst_n     (rst_n),
      .id_vld    (id_vld),
      .src_use   (id_src_use),
      .src_idx   (id_src_idx),
      .prod_vld  (prod_vld),
      .prod_wen  (prod_wen),
      .prod_rd   (prod_rd),
      .data_hold (data_hold)
   );

   hz_port_unit #(.MEM_ARCH(MEM_ARCH)) u_port (
      .mem_vld   (mem_vld),
      .mem_acc   (mem_acc),
      .port_hold (port_hold)
   );

   hz_branch_unit u_br (
      .clk     (clk),
      .rst_n   (rst_n),
      .id_vld  (id_vld),
      .id_br   (id_br),
      .ex_vld  (ex_vld),
      .ex_br   (ex_br),
      .br_hold (br_hold)
   );

   // Data hold freezes decode and feeds a bubble to execute; older stages
   // keep flowing. Fetch idling is an independent condition.
   assign stall_fd   = rst_n && data_hold;
   assign bubble_ex  = rst_n && data_hold;
   assign fetch_hold = rst_n && (port_hold || br_hold);

   always_comb begin
      if (!rst_n) begin
         AST_RESET_QUIET: assert (!stall_fd && !bubble_ex && !fetch_hold); // R11
      end
   end

   AST_BRANCH_IN_EX: assert property (@(posedge clk) disable iff (!rst_n)
      (ex_vld && ex_br) |-> fetch_hold);                           // R8
   AST_EX_PRODUCER: assert property (@(posedge clk) disable iff (!rst_n)
      (id_vld && id_src_use[0] && id_src_idx[REG_AW-1:0] != '0 && ex_vld
       && ex_wen && ex_rd == id_src_idx[REG_AW-1:0]) |-> (stall_fd && bubble_ex)); // R1
   AST_MEM_PRODUCER: assert property (@(posedge clk) disable iff (!rst_n)
      (id_vld && id_src_use[0] && id_src_idx[REG_AW-1:0] != '0 && mem_vld
       && mem_wen && mem_rd == id_src_idx[REG_AW-1:0]) |-> stall_fd); // R2

   generate
      if (MEM_ARCH == hz_pkg::MEM_UNIFIED) begin : g_chk_shared
         AST_PORT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
            (mem_vld && mem_acc) |-> fetch_hold);                  // R6
      end else begin : g_chk_split
         AST_PORT_FREE: assert property (@(posedge clk) disable iff (!rst_n)
            (!id_br && !ex_br) |-> !fetch_hold);                   // R7
      end
   endgenerate
endmodule

// File: tb/sim_hazard_stall_ctrl.sv
module sim_hazard_stall_ctrl;
   localparam int unsigned AW = 5;

   typedef struct packed {
      logic [7:0]    req;
      logic          idv, idbr, u1, u2;
      logic [AW-1:0] rs1, rs2;
      logic          exv, exw, exbr;
      logic [AW-1:0] exrd;
      logic          mv, mw, macc;
      logic [AW-1:0] mrd;
      logic          e_stall, e_fh_u, e_fh_s;
   } vec_t;

   localparam int NV = 17;
   // req | idv idbr u1 u2 rs1 rs2 | exv exw exbr exrd | mv mw macc mrd | stall fh_uni fh_split
   localparam vec_t TBL [NV] = '{
      '{8'd1, 1,0,1,0, 5'd3,5'd0,  1,1,0,5'd3,   0,0,0,5'd0,  1,0,0}, // R1 source 0
      '{8'd1, 1,0,0,1, 5'd0,5'd7,  1,1,0,5'd7,   0,0,0,5'd0,  1,0,0}, // R1 source 1
      '{8'd2, 1,0,1,0, 5'd4,5'd0,  0,0,0,5'd0,   1,1,0,5'd4,  1,0,0}, // R2
      '{8'd4, 1,0,1,1, 5'd0,5'd0,  1,1,0,5'd0,   1,1,0,5'd0,  0,0,0}, // R4
      '{8'd5, 1,0,1,0, 5'd3,5'd0,  1,0,0,5'd3,   0,0,0,5'd0,  0,0,0}, // R5 no write
      '{8'd5, 1,0,1,0, 5'd3,5'd0,  0,1,0,5'd3,   0,1,0,5'd3,  0,0,0}, // R5 invalid
      '{8'd5, 1,0,0,0, 5'd3,5'd3,  1,1,0,5'd3,   0,0,0,5'd0,  0,0,0}, // R5 unused src
      '{8'd10,0,0,1,1, 5'd3,5'd4,  1,1,0,5'd3,   1,1,0,5'd4,  0,0,0}, // R10
      '{8'd6, 1,0,1,0, 5'd2,5'd0,  0,0,0,5'd0,   1,1,1,5'd9,  0,1,0}, // R6 R7 load
      '{8'd6, 1,0,1,0, 5'd9,5'd0,  0,0,0,5'd0,   1,0,1,5'd9,  0,1,0}, // R6 R7 store
      '{8'd6, 1,0,0,0, 5'd0,5'd0,  0,0,0,5'd0,   0,0,1,5'd0,  0,0,0}, // R6 invalid stage
      '{8'd8, 1,1,0,0, 5'd0,5'd0,  0,0,0,5'd0,   0,0,0,5'd0,  0,1,1}, // R8 in decode
      '{8'd8, 0,0,0,0, 5'd0,5'd0,  1,0,1,5'd0,   0,0,0,5'd0,  0,1,1}, // R8 in execute
      '{8'd8, 0,1,0,0, 5'd0,5'd0,  0,0,1,5'd0,   0,0,0,5'd0,  0,0,0}, // R8 invalid
      '{8'd9, 1,0,1,0, 5'd5,5'd0,  1,1,0,5'd5,   1,1,1,5'd6,  1,1,0}, // R9
      '{8'd3, 1,0,1,1, 5'd1,5'd2,  1,1,0,5'd6,   1,1,0,5'd8,  0,0,0}, // R3
      '{8'd1, 1,1,1,0, 5'd3,5'd0,  1,1,0,5'd3,   0,0,0,5'd0,  1,1,1}  // R1 R8 branch waits
   };

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic id_vld = 0, id_br = 0, ex_vld = 0, ex_wen = 0, ex_br = 0;
   logic mem_vld = 0, mem_wen = 0, mem_acc = 0;
   logic [1:0] id_src_use = '0;
   logic [2*AW-1:0] id_src_idx = '0;
   logic [AW-1:0] ex_rd = '0, mem_rd = '0;
   logic s0, b0, f0, s1, b1, f1;
   int checks = 0;
   int errors = 0;
   bit done = 0;

   always #5 clk = ~clk;

   hazard_stall_ctrl #(.REG_AW(AW), .NUM_SRC(2), .MEM_ARCH(hz_pkg::MEM_UNIFIED)) u0 (
      .clk(clk), .rst_n(rst_n), .id_vld(id_vld), .id_br(id_br),
      .id_src_use(id_src_use), .id_src_idx(id_src_idx),
      .ex_vld(ex_vld), .ex_wen(ex_wen), .ex_br(ex_br), .ex_rd(ex_rd),
      .mem_vld(mem_vld), .mem_wen(mem_wen), .mem_acc(mem_acc), .mem_rd(mem_rd),
      .stall_fd(s0), .bubble_ex(b0), .fetch_hold(f0));

   hazard_stall_ctrl #(.REG_AW(AW), .NUM_SRC(2), .MEM_ARCH(hz_pkg::MEM_SPLIT)) u1 (
      .clk(clk), .rst_n(rst_n), .id_vld(id_vld), .id_br(id_br),
      .id_src_use(id_src_use), .id_src_idx(id_src_idx),
      .ex_vld(ex_vld), .ex_wen(ex_wen), .ex_br(ex_br), .ex_rd(ex_rd),
      .mem_vld(mem_vld), .mem_wen(mem_wen), .mem_acc(mem_acc), .mem_rd(mem_rd),
      .stall_fd(s1), .bubble_ex(b1), .fetch_hold(f1));

   task automatic check(input logic act, input logic exp, input string tag);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %b expected %b", tag, act, exp);
      end
   endtask

   task automatic apply(input vec_t v);
      @(negedge clk);
      id_vld = v.idv; id_br = v.idbr; id_src_use = {v.u2, v.u1};
      id_src_idx = {v.rs2, v.rs1};
      ex_vld = v.exv; ex_wen = v.exw; ex_br = v.exbr; ex_rd = v.exrd;
      mem_vld = v.mv; mem_wen = v.mw; mem_acc = v.macc; mem_rd = v.mrd;
      #2;
   endtask

   task automatic check_vec(input vec_t v, input int n);
      string t;
      t = $sformatf("R%0d vec%0d", v.req, n);
      check(s0, v.e_stall, {t, " stall_fd uni"});
      check(b0, v.e_stall, {t, " bubble_ex uni"});
      check(f0, v.e_fh_u,  {t, " fetch_hold uni"});
      check(s1, v.e_stall, {t, " stall_fd split"});
      check(b1, v.e_stall, {t, " bubble_ex split"});
      check(f1, v.e_fh_s,  {t, " fetch_hold split"});
   endtask

   initial begin
      // R11: reset forces outputs low even with a hazard, a load and a branch present
      apply('{8'd11, 1,1,1,0, 5'd5,5'd0, 1,1,1,5'd5, 1,1,1,5'd6, 0,0,0});
      check(s0, 1'b0, "R11 stall_fd in reset");
      check(b0, 1'b0, "R11 bubble_ex in reset");
      check(f0, 1'b0, "R11 fetch_hold in reset");
      check(f1, 1'b0, "R11 fetch_hold split in reset");
      repeat (2) @(posedge clk);
      @(negedge clk) rst_n = 1'b1;

      for (int i = 0; i < NV; i++) begin
         apply(TBL[i]);
         check_vec(TBL[i], i);
      end

      // R9 sequence: producer moves from execute to memory while the port conflict clears
      apply('{8'd9, 1,0,1,0, 5'd5,5'd0, 1,1,0,5'd5, 1,0,1,5'd6, 1,1,0});
      check_vec('{8'd9, 1,0,1,0, 5'd5,5'd0, 1,1,0,5'd5, 1,0,1,5'd6, 1,1,0}, 100);
      apply('{8'd9, 1,0,1,0, 5'd5,5'd0, 0,0,0,5'd0, 1,1,0,5'd5, 1,0,0});
      check_vec('{8'd9, 1,0,1,0, 5'd5,5'd0, 0,0,0,5'd0, 1,1,0,5'd5, 1,0,0}, 101);
      apply('{8'd9, 1,0,1,0, 5'd5,5'd0, 0,0,0,5'd0, 0,0,0,5'd0, 0,0,0});
      check_vec('{8'd9, 1,0,1,0, 5'd5,5'd0, 0,0,0,5'd0, 0,0,0,5'd0, 0,0,0}, 102);

      // R4 on source 1 against a memory-stage writer of index 0
      apply('{8'd4, 1,0,0,1, 5'd0,5'd0, 0,0,0,5'd0, 1,1,0,5'd0, 0,0,0});
      check_vec('{8'd4, 1,0,0,1, 5'd0,5'd0, 0,0,0,5'd0, 1,1,0,5'd0, 0,0,0}, 103);

      // R2 highest index on source 1
      apply('{8'd2, 1,0,0,1, 5'd0,5'd31, 0,0,0,5'd0, 1,1,0,5'd31, 1,0,0});
      check_vec('{8'd2, 1,0,0,1, 5'd0,5'd31, 0,0,0,5'd0, 1,1,0,5'd31, 1,0,0}, 104);

      if (!done) begin
         done = 1;
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      repeat (5000) @(posedge clk);
      if (!done) begin
         done = 1;
         checks++;
         errors++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end
endmodule